// File: doc/BRIEF.md
# Watchdog and Low-Voltage Reset Supervisor

This block produces an active-low reset request for a host processor. It runs from the 32.768 kHz timekeeping clock, and all of its delays are counted in cycles of that clock. Three conditions pull the request low:

- a supply comparator that reports the supply below its trip level;
- a watchdog period that runs out because the host did not service it;
- the power-on reset of the block itself.

Once the cause has cleared, the request stays low for a fixed release stretch of 250 ms (8192 cycles) before it goes high again.

The host restarts the watchdog with a one-cycle service strobe. In a system this strobe stands in for activity on the serial bus. A two-bit code selects one of three watchdog periods: about 1.75 s, 750 ms or 250 ms (57344, 24576 or 8192 cycles). A fourth code value turns the watchdog off. The comparator itself and the open-drain pad are outside the block. The comparator level is expected to arrive already synchronous to the clock.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_req_n` is 0.
- R2: After `rst_n` rises with `vlow` low, `rst_req_n` stays 0 for exactly `HOLD_CYC` clock edges and then goes to 1.
- R3: A clock edge that samples `vlow` high drives `rst_req_n` to 0 on that edge, and it stays 0 for as long as `vlow` stays high.
- R4: Each edge that samples `vlow` high restarts the release stretch. `rst_req_n` rises only after `HOLD_CYC` consecutive edges that sample `vlow` low.
- R5: The `per_sel` encoding is 2'b00 for `PER_LONG_CYC`, 2'b01 for `PER_MID_CYC` and 2'b10 for `PER_SHORT_CYC`. Without service, `rst_req_n` stays 1 for exactly the selected number of edges and then drops to 0.
- R6: With `per_sel` = 2'b11 the watchdog is off, and `rst_req_n` stays 1 while `vlow` is low.
- R7: A service strobe sampled while `rst_req_n` is 1 restarts the period. The next timeout comes the selected number of edges after that strobe.
- R8: After a watchdog timeout, `rst_req_n` stays 0 for exactly `HOLD_CYC` edges, then rises, and the watchdog restarts from zero.
- R9: Service strobes sampled while `rst_req_n` is 0 have no effect, and the release stretch keeps its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| vlow | input | 1 | Supply comparator level, 1 = supply below trip level |
| svc | input | 1 | Watchdog service strobe, one cycle per service |
| per_sel | input | 2 | Watchdog period code (00 long, 01 mid, 10 short, 11 off) |
| rst_req_n | output | 1 | Reset request to the host, active low |

## Verification
The bound checker evaluates four properties on every cycle:

- a low-supply sample forces the request low on the next cycle;
- the request never rises on the cycle right after a low-supply sample;
- every release follows exactly `HOLD_CYC` low cycles since the last low-supply sample;
- a disabled or serviced watchdog never drops a high request.

Only the bench's scenarios show the following:

- that each period code maps to the right timeout length;
- that a service strobe moves the timeout by exactly one period;
- that strobes during a release stretch leave its length unchanged.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_st_e;

  typedef enum logic [1:0] {
    PER_LONG  = 2'd0,
    PER_MID   = 2'd1,
    PER_SHORT = 2'd2,
    PER_OFF   = 2'd3
  } per_sel_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdsup_release.sv
// Counts the release stretch; done while the last cycle of the stretch is reached.
module wdsup_release #(
  parameter int unsigned HOLD_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic done
);
  localparam int unsigned CW = wdsup_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/wdsup_wdog.sv
// Watchdog period counter with code-selected limit; off code holds it at zero.
module wdsup_wdog #(
  parameter int unsigned PER_LONG_CYC  = 57344,
  parameter int unsigned PER_MID_CYC   = 24576,
  parameter int unsigned PER_SHORT_CYC = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       svc,
  input  logic [1:0] sel,
  output logic       expire
);
  import wdsup_pkg::*;

  localparam int unsigned MAXP = max3(PER_LONG_CYC, PER_MID_CYC, PER_SHORT_CYC);
  localparam int unsigned CW   = cnt_width(MAXP);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_last;
  logic          off;

  always_comb begin
    off = 1'b0;
    unique case (per_sel_e'(sel))
      PER_LONG:  lim_last = CW'(PER_LONG_CYC - 1);
      PER_MID:   lim_last = CW'(PER_MID_CYC - 1);
      PER_SHORT: lim_last = CW'(PER_SHORT_CYC - 1);
      default: begin
        lim_last = '0;
        off      = 1'b1;
      end
    endcase
  end

  assign expire = en && !svc && !off && (cnt >= lim_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!en || svc || off || expire) cnt <= '0;
    else                                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned HOLD_CYC      = 8192,
  parameter int unsigned PER_LONG_CYC  = 57344,
  parameter int unsigned PER_MID_CYC   = 24576,
  parameter int unsigned PER_SHORT_CYC = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vlow,
  input  logic       svc,
  input  logic [1:0] per_sel,
  output logic       rst_req_n
);
  import wdsup_pkg::*;

  sup_st_e st, st_nx;
  logic    rel_done;
  logic    wd_expire;
  logic    running;

  assign running = (st == ST_RUN);

  wdsup_release #(.HOLD_CYC(HOLD_CYC)) u_rel (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (vlow || running),
    .done  (rel_done)
  );

  wdsup_wdog #(
    .PER_LONG_CYC (PER_LONG_CYC),
    .PER_MID_CYC  (PER_MID_CYC),
    .PER_SHORT_CYC(PER_SHORT_CYC)
  ) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (running && !vlow),
    .svc    (svc),
    .sel    (per_sel),
    .expire (wd_expire)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_HOLD: if (!vlow && rel_done)  st_nx = ST_RUN;
      ST_RUN:  if (vlow || wd_expire) st_nx = ST_HOLD;
      default: st_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_HOLD;
    else        st <= st_nx;
  end

  assign rst_req_n = running;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int unsigned HOLD_CYC = 8192
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vlow,
  input logic       svc,
  input logic [1:0] per_sel,
  input logic       rst_req_n
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_run <= 0;
    else if (vlow || rst_req_n)         low_run <= 0;
    else if (low_run != 32'hFFFF_FFFF)  low_run <= low_run + 1;
  end

  // R3
  vlow_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !rst_req_n);

  // R4
  no_release_after_vlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n) |-> !$past(vlow));

  // R2
  release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n) |-> (low_run == HOLD_CYC));

  // R6
  wdog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_n && !vlow && per_sel == 2'b11) |=> rst_req_n);

  // R7
  svc_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_n && !vlow && svc) |=> rst_req_n);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vlow     (vlow),
  .svc      (svc),
  .per_sel  (per_sel),
  .rst_req_n(rst_req_n)
);

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HOLD = 20;
  localparam int PL = 90;
  localparam int PM = 50;
  localparam int PS = 30;

  // {per_sel code, expected high length}
  localparam int VEC [4][2] = '{'{0, PL}, '{1, PM}, '{2, PS}, '{1, PM}};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vlow;
  logic       svc;
  logic [1:0] per_sel;
  logic       rst_req_n;

  int  errs = 0;
  int  checks = 0;
  bit  ended = 0;

  always #2.5 clk = ~clk;

  wdog_supervisor #(
    .HOLD_CYC(HOLD), .PER_LONG_CYC(PL), .PER_MID_CYC(PM), .PER_SHORT_CYC(PS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .svc(svc),
    .per_sel(per_sel), .rst_req_n(rst_req_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cnt_lvl(input logic lvl, output int n);
    n = 0;
    while (rst_req_n === lvl && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    bit all_ok;
    rst_n = 1'b0; vlow = 1'b0; svc = 1'b0; per_sel = 2'b11;
    repeat (3) @(negedge clk);
    chk(rst_req_n === 1'b0, "R1", rst_req_n, 0);

    // R2 power-up stretch
    rst_n = 1'b1;
    cnt_lvl(1'b0, n);
    chk(n == HOLD, "R2", n, HOLD);

    // R6 watchdog off
    all_ok = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rst_req_n !== 1'b1) all_ok = 0;
    end
    chk(all_ok, "R6", all_ok, 1);

    // R5 / R8 table of period codes
    for (int i = 0; i < 4; i++) begin
      per_sel = VEC[i][0][1:0];
      cnt_lvl(1'b1, n);
      chk(n == VEC[i][1], "R5", n, VEC[i][1]);
      cnt_lvl(1'b0, n);
      chk(n == HOLD, "R8", n, HOLD);
    end

    // R7 servicing
    per_sel = 2'b10;
    for (int k = 0; k < 5; k++) begin
      repeat (20) @(negedge clk);
      svc = 1'b1;
      @(negedge clk);
      svc = 1'b0;
      chk(rst_req_n === 1'b1, "R7", rst_req_n, 1);
    end
    cnt_lvl(1'b1, n);
    chk(n == PS, "R7", n, PS);

    // R9 strobes during the stretch
    svc = 1'b1;
    cnt_lvl(1'b0, n);
    svc = 1'b0;
    chk(n == HOLD, "R9", n, HOLD);
    per_sel = 2'b11;

    // R3 low supply
    repeat (5) @(negedge clk);
    vlow = 1'b1;
    @(negedge clk);
    chk(rst_req_n === 1'b0, "R3", rst_req_n, 0);
    all_ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_req_n !== 1'b0) all_ok = 0;
    end
    chk(all_ok, "R3", all_ok, 1);

    // R4 release after recovery, and restart mid-stretch
    vlow = 1'b0;
    cnt_lvl(1'b0, n);
    chk(n == HOLD, "R4", n, HOLD);
    vlow = 1'b1;
    @(negedge clk);
    vlow = 1'b0;
    repeat (10) @(negedge clk);
    vlow = 1'b1;
    @(negedge clk);
    vlow = 1'b0;
    cnt_lvl(1'b0, n);
    chk(n == HOLD, "R4", n, HOLD);

    finish_run();
  end
endmodule